// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Register

This block is the digital control side of an analog-to-digital converter. Software talks to it through a byte-wide register port with three addresses: a control/status byte, and the high and low bytes of the last result. The control byte holds the completion flag, the interrupt enable, the repeat-mode bit and a 5-bit channel code. A conversion starts either on a write to the control byte (software mode) or on a trigger pulse (hardware mode). It then runs once or repeats back to back.

The converter itself sits outside the block and is reached through a level request and a one-cycle done pulse. The done pulse comes with a result word and a compare-true bit. When the external compare function is enabled, a conversion only counts as complete if its compare result is true. Only a complete conversion sets the flag, latches the result and can raise the interrupt. The channel code is also decoded into a kind: analog input, reserved, high reference, or converter off. The all-ones code shuts the converter down at once.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the control byte reads 0x1F (flag, interrupt enable and repeat bit clear, channel code all ones), `irq` is low and `conv_req` is low.
- R2: With `cmp_en` low, every done pulse during a conversion sets the flag (control bit 7) and latches `conv_result`.
- R3: With `cmp_en` high, a done pulse sets the flag and latches the result only when `conv_cmp_true` is high; otherwise the flag and the result keep their values.
- R4: The flag clears on any write to the control byte (address 0) or on a read of the result low byte (address 2), unless a completing done pulse arrives in the same cycle.
- R5: `irq` is high exactly while the flag and the interrupt enable (control bit 6) are both set.
- R6: In software mode (`hw_mode` low), a control write whose channel code is not 11111 raises `conv_req` on the next cycle. With the repeat bit (control bit 5) clear, `conv_req` drops after the done pulse.
- R7: With the repeat bit set, `conv_req` stays high after each done pulse, so conversions run back to back.
- R8: A control write with channel code 11111 drops `conv_req` on the next cycle, discards a done pulse in that same cycle and starts no further conversion.
- R9: In hardware mode a control write starts nothing; a `hw_trig` pulse starts a conversion unless the channel code is 11111.
- R10: A trigger (control write or `hw_trig`) that arrives while a conversion is in progress starts nothing extra: a single conversion still ends after one done pulse.
- R11: `chan_kind` decodes the channel code: 0 (input) for 00000 to 11011, 1 (reserved) for 11100 and 11101, 2 (high reference) for 11110, 3 (off) for 11111. `conv_chan` carries the code.
- R12: Address 1 reads the result bits above bit 7, zero-extended; address 2 reads result bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 result high, 2 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| hw_mode | input | 1 | 1 selects hardware-triggered starts |
| hw_trig | input | 1 | Hardware trigger pulse |
| cmp_en | input | 1 | Compare function enable |
| conv_req | output | 1 | Conversion in progress / request to converter |
| conv_chan | output | 5 | Channel code presented to the converter |
| chan_kind | output | 2 | Decoded kind of the channel code |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| conv_result | input | RES_W | Converted value, valid with `conv_done` |
| conv_cmp_true | input | 1 | Compare outcome, valid with `conv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong busy state shows on `conv_req` one cycle after the event that corrupted it. For example, a missed abort leaves the request high, and a lost repeat drops it after the next done pulse. A flag that is set or cleared wrongly shows on `irq` and in bit 7 of the control byte in the cycle after the done pulse, the read or the write. A wrong compare gate or a stale result latch only shows when the result bytes are read back. So every conversion in the sweep is followed by reads of both result bytes.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int CHAN_W = 5;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_RES_HI = 2'd1;
  localparam logic [1:0] REG_RES_LO = 2'd2;

  typedef enum logic [1:0] {
    CK_INPUT    = 2'd0,
    CK_RESERVED = 2'd1,
    CK_VREFH    = 2'd2,
    CK_OFF      = 2'd3
  } chan_kind_e;

  // classify a channel code
  function automatic chan_kind_e kind_of(input logic [CHAN_W-1:0] code);
    if (&code)                             return CK_OFF;
    else if (&code[CHAN_W-1:1])            return CK_VREFH;
    else if (&code[CHAN_W-1:CHAN_W-3])     return CK_RESERVED;
    else                                   return CK_INPUT;
  endfunction

  // does a finished conversion count as complete
  function automatic logic counts_complete(input logic cmp_on, input logic cmp_hit);
    return !cmp_on || cmp_hit;
  endfunction
endpackage

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
  import adc_ctrl_pkg::*;
(
  input  logic [CHAN_W-1:0] code,
  output chan_kind_e        kind,
  output logic              is_off
);
  always_comb begin
    kind   = kind_of(code);
    is_off = (kind == CK_OFF);
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_code_off,
  input  logic cur_code_off,
  input  logic repeat_on,
  input  logic hw_mode,
  input  logic hw_trig,
  input  logic conv_done,
  output logic busy,
  output logic start_evt,
  output logic abort_evt,
  output logic done_evt
);
  logic sw_go;
  logic hw_go;

  always_comb begin
    abort_evt = ctrl_wr && wr_code_off;
    sw_go     = ctrl_wr && !hw_mode && !wr_code_off;
    hw_go     = hw_mode && hw_trig && !cur_code_off && !abort_evt;
    start_evt = !busy && (sw_go || hw_go);
    done_evt  = busy && conv_done && !abort_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (abort_evt)  busy <= 1'b0;
    else if (start_evt)  busy <= 1'b1;
    else if (done_evt)   busy <= repeat_on;
  end
endmodule

// File: rtl/adc_status.sv
module adc_status
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        wdata,
  input  logic              low_rd,
  input  logic              done_evt,
  input  logic              complete_ok,
  input  logic [RES_W-1:0]  result_in,
  output logic              flag,
  output logic              ien,
  output logic              repeat_on,
  output logic [CHAN_W-1:0] chan,
  output logic [RES_W-1:0]  result
);
  logic complete_evt;
  assign complete_evt = done_evt && complete_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien       <= 1'b0;
      repeat_on <= 1'b0;
      chan      <= '1;
    end else if (ctrl_wr) begin
      ien       <= wdata[6];
      repeat_on <= wdata[5];
      chan      <= wdata[CHAN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (complete_evt)      flag <= 1'b1;
    else if (ctrl_wr || low_rd) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            result <= '0;
    else if (complete_evt) result <= result_in;
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             hw_mode,
  input  logic             hw_trig,
  input  logic             cmp_en,
  output logic             conv_req,
  output logic [4:0]       conv_chan,
  output logic [1:0]       chan_kind,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             conv_cmp_true,
  output logic             irq
);
  localparam int EXT_W = 16;

  // named internal events
  logic ctrl_wr, low_rd;
  logic start_evt, abort_evt, done_evt, complete_ok;
  logic busy, flag_q, ien_q, cont_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  result_q;
  logic [EXT_W-1:0]  result_ext;
  chan_kind_e cur_kind, wr_kind;
  logic cur_off, wr_off;

  assign ctrl_wr     = bus_wr && (bus_addr == REG_CTRL);
  assign low_rd      = bus_rd && (bus_addr == REG_RES_LO);
  assign complete_ok = counts_complete(cmp_en, conv_cmp_true);

  adc_chan_decode u_cur_dec (.code(chan_q), .kind(cur_kind), .is_off(cur_off));
  adc_chan_decode u_wr_dec  (.code(bus_wdata[CHAN_W-1:0]), .kind(wr_kind), .is_off(wr_off));

  adc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_code_off(wr_off),
    .cur_code_off(cur_off), .repeat_on(cont_q), .hw_mode(hw_mode),
    .hw_trig(hw_trig), .conv_done(conv_done), .busy(busy),
    .start_evt(start_evt), .abort_evt(abort_evt), .done_evt(done_evt)
  );

  adc_status #(.RES_W(RES_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .low_rd(low_rd), .done_evt(done_evt), .complete_ok(complete_ok),
    .result_in(conv_result), .flag(flag_q), .ien(ien_q), .repeat_on(cont_q),
    .chan(chan_q), .result(result_q)
  );

  assign result_ext = EXT_W'(result_q);
  assign conv_req   = busy;
  assign conv_chan  = chan_q;
  assign chan_kind  = cur_kind;
  assign irq        = flag_q && ien_q;

  always_comb begin
    unique case (bus_addr)
      REG_CTRL:   bus_rdata = {flag_q, ien_q, cont_q, chan_q};
      REG_RES_HI: bus_rdata = result_ext[15:8];
      REG_RES_LO: bus_rdata = result_ext[7:0];
      default:    bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       cmp_en,
  input logic       conv_done,
  input logic       conv_cmp_true,
  input logic       conv_req,
  input logic       irq,
  input logic       flag_q,
  input logic       cont_q
);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && !conv_done) |=> !flag_q);

  p_cmp_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && conv_done && cmp_en && !conv_cmp_true) |=> !flag_q);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(conv_done) || $past(bus_wr)));

  p_single_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && !cont_q && !bus_wr) |=> !conv_req);

  p_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && cont_q && !bus_wr) |=> conv_req);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && (&bus_wdata[4:0])) |=> !conv_req);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !(bus_wr && bus_addr == 2'd0)) |=> conv_req);
endmodule

bind adc_ctrl adc_ctrl_chk u_chk (.*);

// File: tb/tb_adc_ctrl.sv
module tb_adc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic hw_mode = 0, hw_trig = 0, cmp_en = 0;
  logic conv_req, conv_done = 0, conv_cmp_true = 0, irq;
  logic [4:0] conv_chan;
  logic [1:0] chan_kind;
  logic [RES_W-1:0] conv_result = 0;

  int checks = 0, fails = 0;
  logic [RES_W-1:0] exp_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctrl #(.RES_W(RES_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = 2'd0; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic done(input logic [RES_W-1:0] r, input logic ct);
    @(negedge clk); conv_done = 1; conv_result = r; conv_cmp_true = ct;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic read_low(output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = 2'd2; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int kind_ref(input int c);
    if (c == 31) return 3;
    if (c == 30) return 2;
    if (c >= 28) return 1;
    return 0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 8'h1F);
    chk("R1 irq", irq, 0); chk("R1 req", conv_req, 0);

    // R11 and R9: decode sweep in hardware mode, writes start nothing
    hw_mode = 1;
    for (int c = 0; c < 32; c++) begin
      wr(8'(c));
      chk("R11 kind", chan_kind, kind_ref(c));
      chk("R11 chan", conv_chan, c);
      chk("R9 no start on write", conv_req, 0);
    end
    hw_mode = 0;

    // R2 R3 R5 R6 R12 R4: compare/interrupt sweep
    n = 0;
    for (int ce = 0; ce < 2; ce++)
      for (int ct = 0; ct < 2; ct++)
        for (int ie = 0; ie < 2; ie++) begin
          logic [RES_W-1:0] r;
          logic ok;
          r = RES_W'((n * 1123 + 291) % (1 << RES_W));
          n++;
          cmp_en = ce[0];
          ok = !ce[0] || ct[0];
          wr({1'b0, ie[0], 1'b0, 5'd3});
          chk("R6 req up", conv_req, 1);
          peek(2'd0, d); chk("R4 write clears", d[7], 0);
          done(r, ct[0]);
          if (ok) exp_res = r;
          peek(2'd0, d); chk(ce ? "R3 flag" : "R2 flag", d[7], ok);
          chk("R5 irq", irq, ok && ie[0]);
          chk("R6 req down", conv_req, 0);
          peek(2'd1, d); chk("R12 high", d, 32'(exp_res) >> 8);
          read_low(d); chk("R12 low", d, exp_res & 8'hFF);
          peek(2'd0, d); chk("R4 read clears", d[7], 0);
          chk("R5 irq off", irq, 0);
        end
    cmp_en = 0;

    // R4 write path with no start
    wr(8'h43); done(12'h5A5, 0); exp_res = 12'h5A5;
    chk("R5 irq set", irq, 1);
    wr(8'h5F);
    peek(2'd0, d); chk("R4 write clears flag", d[7], 0);
    chk("R8 no start", conv_req, 0);

    // R10 software trigger during a single conversion
    wr(8'h04); chk("R6 start", conv_req, 1);
    wr(8'h05); chk("R10 still busy", conv_req, 1);
    done(12'h111, 0); exp_res = 12'h111;
    chk("R10 one conversion only", conv_req, 0);
    idle(3); chk("R10 no restart", conv_req, 0);

    // R7 repeat mode and R8 abort
    wr(8'h25); chk("R7 start", conv_req, 1);
    for (int k = 0; k < 3; k++) begin
      done(RES_W'(k + 7), 0); exp_res = RES_W'(k + 7);
      chk("R7 stays busy", conv_req, 1);
      peek(2'd0, d); chk("R2 flag in repeat", d[7], 1);
    end
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'h3F;
    conv_done = 1; conv_result = 12'hABC; conv_cmp_true = 1;
    @(negedge clk); bus_wr = 0; conv_done = 0;
    chk("R8 abort drops req", conv_req, 0);
    peek(2'd0, d); chk("R8 flag not set", d[7], 0);
    peek(2'd1, d); chk("R8 result kept", d, 32'(exp_res) >> 8);
    idle(5); chk("R8 no extra conversion", conv_req, 0);

    // R9 hardware triggers and R10 ignored retrigger
    hw_mode = 1;
    wr(8'h02); chk("R9 write no start", conv_req, 0);
    @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R9 trig start", conv_req, 1);
    @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R10 busy", conv_req, 1);
    done(12'h0F0, 0); exp_res = 12'h0F0;
    chk("R10 single ends", conv_req, 0);
    idle(3); chk("R10 no queued start", conv_req, 0);
    wr(8'h1F);
    @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R9 off code blocks trig", conv_req, 0);
    wr(8'h22);
    @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
    done(12'h321, 0);
    chk("R7 hw repeat", conv_req, 1);
    wr(8'h3F); chk("R8 hw abort", conv_req, 0);
    hw_mode = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule